// File: doc/BRIEF.md
# Queue Controller Register Front End

This block is the 32-bit register face of a storage queue controller. Host software uses it to read the fixed capability and version words and to program the interrupt mask, the controller configuration and the admin queue sizes and base addresses. Software also reads the controller status word here, and it rings the queue doorbells through the same port. The block does no command fetching or host memory traffic. It keeps the control state, and it turns every accepted doorbell write into a one-cycle event that carries the queue number, the doorbell kind and the written pointer.

Every access is a full 32-bit word. Byte offsets 0x000 to 0xFFF hold the control registers. From 0x1000 upward, each queue owns a pair of 4-byte doorbells 8 bytes apart: first the submission tail, then the completion head. Queue 0 is the admin queue. Writing the configuration word is the enable handshake. A 0-to-1 edge on the enable bit snapshots the admin queue setup and raises ready. A 1-to-0 edge drops ready. A normal shutdown request reports shutdown complete.

Top module: `nvq_regfront`

## Requirements
- R1: After reset, offset 0x00 reads 0x0A010010 (max queue entries 0x10 in bits 15:0, contiguous-queues bit 16 set, timeout 10 in bits 31:24). Offset 0x04 reads 0, offset 0x08 reads 0x00010000, and the configuration (0x14), status (0x1C) and queue-attribute (0x24) words read 0.
- R2: A read of an unmapped offset (including 0x18 and any offset whose low two bits are not zero) returns 0. Writes to unmapped offsets are ignored, and so are writes to the read-only words 0x00, 0x04, 0x08 and 0x1C.
- R3: An access whose byte enables are not all four set is ignored: no register changes, no doorbell event is raised, and a read returns 0.
- R4: A write to 0x0C ORs the written bits into the interrupt mask. A write to 0x10 clears the written bits. Both offsets read the mask.
- R5: The queue-attribute word at 0x24 keeps bits 27:16 and 11:0. The low words of the submission base (0x28) and completion base (0x30) keep bits 31:12. The high words (0x2C, 0x34) keep all 32 bits.
- R6: The configuration word at 0x14 keeps enable (bit 0), command set (6:4), page size (10:7), arbitration (13:11), shutdown request (15:14), submission entry size (19:16) and completion entry size (23:20). All other bits read 0.
- R7: A configuration write that takes enable from 0 to 1 does three things: it clears the interrupt mask, it sets status bit 0 (ready), and it copies the base and size words into the admin setup outputs (submission size from 0x24 bits 11:0, completion size from bits 27:16). A write that leaves enable at 1 does none of this. Later base writes do not change the admin outputs.
- R8: A configuration write that takes enable from 1 to 0 clears ready.
- R9: A configuration write with shutdown request 1 sets status bits 3:2 to 2 (shutdown complete). Request 0 leaves them unchanged. A 0-to-1 enable edge returns them to 0 unless the same write requests a normal shutdown.
- R10: A write at 0x1000 + 8*q reports a submission-tail doorbell for queue q. A write at 0x1000 + 8*q + 4 reports a completion-head doorbell. The event is valid for exactly one cycle, starting the cycle after the write, and carries bits 15:0 of the write data.
- R11: A doorbell write to a queue number at or above the implemented count raises no event and sets an error flag. The flag stays set until reset.
- R12: Read data and its valid strobe appear the cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Byte offset |
| byte_en | input | 4 | Byte enables; only 4'hF is accepted |
| wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| bell_valid | output | 1 | Doorbell event strobe |
| bell_qid | output | QID_W | Queue number of the event |
| bell_is_cq | output | 1 | 1 = completion head, 0 = submission tail |
| bell_ptr | output | PTR_W | Written pointer value |
| bell_err | output | 1 | Sticky out-of-range doorbell flag |
| adm_sq_base | output | 64 | Admin submission base captured at enable |
| adm_cq_base | output | 64 | Admin completion base captured at enable |
| adm_sq_size | output | 12 | Admin submission size captured at enable |
| adm_cq_size | output | 12 | Admin completion size captured at enable |

## Verification
The bench builds the block with its default parameters: a 13-bit offset, two queue pairs and 16-bit pointers. With these values, 0x1010 is the first doorbell outside the implemented range, so the drop-and-flag path is reached by one write. The full 13-bit window also lets the bench hit far out-of-range doorbells such as 0x1FF8. The two-queue count makes it possible to tell the admin and I/O pairs apart in both doorbell kinds.

// File: rtl/nvq_pkg.sv
// Package: shared select codes and field constants for the queue register front end.
// Assumes a 13-bit byte offset with doorbells in the upper half of the window.
package nvq_pkg;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CAPL, SEL_CAPH, SEL_VER, SEL_MSET, SEL_MCLR,
        SEL_CFG, SEL_STAT, SEL_AQA, SEL_ASQL, SEL_ASQH, SEL_ACQL,
        SEL_ACQH, SEL_BELL
    } nvq_sel_e;

    localparam int          OFS_CAPL = 'h00;
    localparam int          OFS_CAPH = 'h04;
    localparam int          OFS_VER  = 'h08;
    localparam int          OFS_MSET = 'h0C;
    localparam int          OFS_MCLR = 'h10;
    localparam int          OFS_CFG  = 'h14;
    localparam int          OFS_STAT = 'h1C;
    localparam int          OFS_AQA  = 'h24;
    localparam int          OFS_ASQL = 'h28;
    localparam int          OFS_ASQH = 'h2C;
    localparam int          OFS_ACQL = 'h30;
    localparam int          OFS_ACQH = 'h34;

    localparam logic [31:0] CFG_KEEP     = 32'h00FF_FFF1;
    localparam logic [31:0] AQA_KEEP     = 32'h0FFF_0FFF;
    localparam logic [31:0] BASE_LO_KEEP = 32'hFFFF_F000;
    localparam int          CFG_SHN_LSB  = 14;
    localparam logic [1:0]  SHN_NORMAL   = 2'b01;
    localparam logic [1:0]  SHST_IDLE    = 2'b00;
    localparam logic [1:0]  SHST_DONE    = 2'b10;
    localparam int          AQS_W        = 12;

endpackage

// File: rtl/nvq_addr_dec.sv
// Address decoder: maps a word offset to a register select, or to a doorbell
// queue number and kind. Assumes the doorbell area is the upper half of the
// offset window and that only full-word, word-aligned accesses are legal.
module nvq_addr_dec
    import nvq_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int NQ     = 2,
    parameter int QID_W  = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        byte_en,
    output nvq_sel_e          sel,
    output logic [QID_W-1:0]  qid,
    output logic              is_cq,
    output logic              qid_ok
);
    localparam int LOW_W  = ADDR_W - 1;
    localparam int QIDX_W = ADDR_W - 4;

    logic              legal;
    logic [QIDX_W-1:0] qidx;

    // Legal access: all byte lanes enabled and word aligned.
    always_comb legal = (byte_en == 4'hF) && (addr[1:0] == 2'b00);

    // Doorbell fields: queue index from bits above the pair stride, kind from bit 2.
    always_comb begin
        qidx   = addr[ADDR_W-2:3];
        qid    = qidx[QID_W-1:0];
        is_cq  = addr[2];
        qid_ok = (int'(qidx) < NQ);
    end

    // Register select from the low window, or doorbell in the high window.
    always_comb begin
        sel = SEL_NONE;
        if (legal) begin
            if (addr[ADDR_W-1]) begin
                sel = SEL_BELL;
            end else begin
                case (addr[LOW_W-1:0])
                    LOW_W'(OFS_CAPL): sel = SEL_CAPL;
                    LOW_W'(OFS_CAPH): sel = SEL_CAPH;
                    LOW_W'(OFS_VER):  sel = SEL_VER;
                    LOW_W'(OFS_MSET): sel = SEL_MSET;
                    LOW_W'(OFS_MCLR): sel = SEL_MCLR;
                    LOW_W'(OFS_CFG):  sel = SEL_CFG;
                    LOW_W'(OFS_STAT): sel = SEL_STAT;
                    LOW_W'(OFS_AQA):  sel = SEL_AQA;
                    LOW_W'(OFS_ASQL): sel = SEL_ASQL;
                    LOW_W'(OFS_ASQH): sel = SEL_ASQH;
                    LOW_W'(OFS_ACQL): sel = SEL_ACQL;
                    LOW_W'(OFS_ACQH): sel = SEL_ACQH;
                    default:          sel = SEL_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/nvq_ctrl_regs.sv
// Control state: interrupt mask, configuration, status, admin queue attribute
// and base words, plus the admin setup snapshot taken on the enable edge.
// Assumes wr_stb is qualified by the decoder (sel is SEL_NONE when illegal).
module nvq_ctrl_regs
    import nvq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  nvq_sel_e         sel,
    input  logic [31:0]      wdata,
    output logic [31:0]      cfg_q,
    output logic [31:0]      mask_q,
    output logic [31:0]      aqa_q,
    output logic [31:0]      asq_lo_q,
    output logic [31:0]      asq_hi_q,
    output logic [31:0]      acq_lo_q,
    output logic [31:0]      acq_hi_q,
    output logic             rdy_q,
    output logic [1:0]       shst_q,
    output logic [63:0]      adm_sq_base,
    output logic [63:0]      adm_cq_base,
    output logic [AQS_W-1:0] adm_sq_size,
    output logic [AQS_W-1:0] adm_cq_size
);
    logic cfg_wr, en_rise, en_fall, shn_norm;

    // Configuration write side-effect strobes.
    always_comb begin
        cfg_wr   = wr_stb && (sel == SEL_CFG);
        en_rise  = cfg_wr && !cfg_q[0] && wdata[0];
        en_fall  = cfg_wr && cfg_q[0] && !wdata[0];
        shn_norm = cfg_wr && (wdata[CFG_SHN_LSB +: 2] == SHN_NORMAL);
    end

    // Configuration word storage with reserved bits dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= wdata & CFG_KEEP;
    end

    // Ready bit follows the enable edges.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdy_q <= 1'b0;
        else if (en_rise) rdy_q <= 1'b1;
        else if (en_fall) rdy_q <= 1'b0;
    end

    // Shutdown status: cleared by the enable edge, set by a normal request.
    always_ff @(posedge clk) begin
        if (!rst_n)        shst_q <= SHST_IDLE;
        else if (en_rise)  shst_q <= shn_norm ? SHST_DONE : SHST_IDLE;
        else if (shn_norm) shst_q <= SHST_DONE;
    end

    // Interrupt mask: set/clear ports, cleared to default on the enable edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask_q <= '0;
        else if (en_rise)                     mask_q <= '0;
        else if (wr_stb && sel == SEL_MSET)   mask_q <= mask_q | wdata;
        else if (wr_stb && sel == SEL_MCLR)   mask_q <= mask_q & ~wdata;
    end

    // Admin queue attribute and base words as software programs them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aqa_q    <= '0;
            asq_lo_q <= '0;
            asq_hi_q <= '0;
            acq_lo_q <= '0;
            acq_hi_q <= '0;
        end else if (wr_stb) begin
            case (sel)
                SEL_AQA:  aqa_q    <= wdata & AQA_KEEP;
                SEL_ASQL: asq_lo_q <= wdata & BASE_LO_KEEP;
                SEL_ASQH: asq_hi_q <= wdata;
                SEL_ACQL: acq_lo_q <= wdata & BASE_LO_KEEP;
                SEL_ACQH: acq_hi_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Admin setup snapshot taken only on the enable rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adm_sq_base <= '0;
            adm_cq_base <= '0;
            adm_sq_size <= '0;
            adm_cq_size <= '0;
        end else if (en_rise) begin
            adm_sq_base <= {asq_hi_q, asq_lo_q};
            adm_cq_base <= {acq_hi_q, acq_lo_q};
            adm_sq_size <= aqa_q[AQS_W-1:0];
            adm_cq_size <= aqa_q[16 +: AQS_W];
        end
    end

endmodule

// File: rtl/nvq_bell_out.sv
// Doorbell event stage: registers an in-range doorbell write into a one-cycle
// event and records out-of-range queue numbers in a sticky flag.
// Assumes bell_stb is already qualified as a legal doorbell write.
module nvq_bell_out #(
    parameter int QID_W = 1,
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bell_stb,
    input  logic             qid_ok,
    input  logic [QID_W-1:0] qid,
    input  logic             is_cq,
    input  logic [PTR_W-1:0] ptr,
    output logic             bell_valid,
    output logic [QID_W-1:0] bell_qid,
    output logic             bell_is_cq,
    output logic [PTR_W-1:0] bell_ptr,
    output logic             bell_err
);
    // Event strobe: high for one cycle per accepted in-range doorbell.
    always_ff @(posedge clk) begin
        if (!rst_n) bell_valid <= 1'b0;
        else        bell_valid <= bell_stb && qid_ok;
    end

    // Event payload captured with the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bell_qid   <= '0;
            bell_is_cq <= 1'b0;
            bell_ptr   <= '0;
        end else if (bell_stb && qid_ok) begin
            bell_qid   <= qid;
            bell_is_cq <= is_cq;
            bell_ptr   <= ptr;
        end
    end

    // Sticky flag for dropped out-of-range doorbells.
    always_ff @(posedge clk) begin
        if (!rst_n)                   bell_err <= 1'b0;
        else if (bell_stb && !qid_ok) bell_err <= 1'b1;
    end

endmodule

// File: rtl/nvq_regfront.sv
// Top: register and doorbell front end of a storage queue controller.
// Decodes 32-bit accesses, holds control state, returns read data one cycle
// after the request and emits doorbell events. Assumes one access per cycle.
module nvq_regfront
    import nvq_pkg::*;
#(
    parameter int          ADDR_W   = 13,
    parameter int          NQ       = 2,
    parameter int          PTR_W    = 16,
    parameter logic [15:0] MQES     = 16'h0010,
    parameter logic [7:0]  TO_UNITS = 8'd10,
    parameter logic [31:0] VERSION  = 32'h0001_0000,
    localparam int         QID_W    = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        byte_en,
    input  logic [31:0]       wdata,
    output logic              rd_valid,
    output logic [31:0]       rdata,
    output logic              bell_valid,
    output logic [QID_W-1:0]  bell_qid,
    output logic              bell_is_cq,
    output logic [PTR_W-1:0]  bell_ptr,
    output logic              bell_err,
    output logic [63:0]       adm_sq_base,
    output logic [63:0]       adm_cq_base,
    output logic [11:0]       adm_sq_size,
    output logic [11:0]       adm_cq_size
);
    localparam logic [31:0] CAP_LO = {TO_UNITS, 7'b0, 1'b1, MQES};

    nvq_sel_e         sel;
    logic [QID_W-1:0] dec_qid;
    logic             dec_is_cq, dec_qid_ok;
    logic [31:0]      cfg_q, mask_q, aqa_q, asq_lo_q, asq_hi_q, acq_lo_q, acq_hi_q;
    logic             rdy_q;
    logic [1:0]       shst_q;
    logic [31:0]      rd_mux;

    nvq_addr_dec #(.ADDR_W(ADDR_W), .NQ(NQ), .QID_W(QID_W)) u_dec (
        .addr(addr), .byte_en(byte_en), .sel(sel),
        .qid(dec_qid), .is_cq(dec_is_cq), .qid_ok(dec_qid_ok)
    );

    nvq_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_en), .sel(sel), .wdata(wdata),
        .cfg_q(cfg_q), .mask_q(mask_q), .aqa_q(aqa_q),
        .asq_lo_q(asq_lo_q), .asq_hi_q(asq_hi_q),
        .acq_lo_q(acq_lo_q), .acq_hi_q(acq_hi_q),
        .rdy_q(rdy_q), .shst_q(shst_q),
        .adm_sq_base(adm_sq_base), .adm_cq_base(adm_cq_base),
        .adm_sq_size(adm_sq_size), .adm_cq_size(adm_cq_size)
    );

    nvq_bell_out #(.QID_W(QID_W), .PTR_W(PTR_W)) u_bell (
        .clk(clk), .rst_n(rst_n),
        .bell_stb(wr_en && (sel == SEL_BELL)),
        .qid_ok(dec_qid_ok), .qid(dec_qid), .is_cq(dec_is_cq),
        .ptr(wdata[PTR_W-1:0]),
        .bell_valid(bell_valid), .bell_qid(bell_qid), .bell_is_cq(bell_is_cq),
        .bell_ptr(bell_ptr), .bell_err(bell_err)
    );

    // Read data selection; doorbells and unmapped offsets read zero.
    always_comb begin
        case (sel)
            SEL_CAPL:           rd_mux = CAP_LO;
            SEL_VER:            rd_mux = VERSION;
            SEL_MSET, SEL_MCLR: rd_mux = mask_q;
            SEL_CFG:            rd_mux = cfg_q;
            SEL_STAT:           rd_mux = {28'b0, shst_q, 1'b0, rdy_q};
            SEL_AQA:            rd_mux = aqa_q;
            SEL_ASQL:           rd_mux = asq_lo_q;
            SEL_ASQH:           rd_mux = asq_hi_q;
            SEL_ACQL:           rd_mux = acq_lo_q;
            SEL_ACQH:           rd_mux = acq_hi_q;
            default:            rd_mux = '0;
        endcase
    end

    // Registered read return, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rdata    <= '0;
        end else begin
            rd_valid <= rd_en;
            rdata    <= rd_en ? rd_mux : '0;
        end
    end

endmodule

// File: rtl/nvq_regfront_chk.sv
// Checker: temporal properties of the register front end, bound to the top.
// Assumes the default doorbell layout (upper half of the offset window).
module nvq_regfront_chk #(
    parameter int ADDR_W = 13,
    parameter int NQ     = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [3:0]        byte_en,
    input logic              cc_en_bit,
    input logic              rd_valid,
    input logic [31:0]       rdata,
    input logic              bell_valid,
    input logic              bell_err,
    input logic              rdy
);
    logic live;
    logic cfg_wr_now, bell_wr_now, bad_bell_now;

    // Marks cycles that have at least one post-reset cycle behind them.
    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // Port-level access classification for the properties.
    always_comb begin
        cfg_wr_now   = wr_en && byte_en == 4'hF && addr == ADDR_W'('h14);
        bell_wr_now  = wr_en && byte_en == 4'hF && addr[ADDR_W-1] && addr[1:0] == 2'b00;
        bad_bell_now = bell_wr_now && (int'(addr[ADDR_W-2:3]) >= NQ);
    end

    p_bell_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (live && bell_valid) |-> $past(bell_wr_now));

    p_bell_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bell_valid && !wr_en) |=> !bell_valid);

    p_bad_bell_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(bad_bell_now)) |-> (!bell_valid && bell_err));

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bell_err |=> bell_err);

    p_rdy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $rose(rdy)) |-> $past(cfg_wr_now && cc_en_bit));

    p_rdy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $fell(rdy)) |-> $past(cfg_wr_now && !cc_en_bit));

    p_rd_follow_r12: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (rd_valid == $past(rd_en)));

    p_partial_rd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(rd_en && byte_en != 4'hF)) |-> (rdata == 32'h0));

endmodule

bind nvq_regfront nvq_regfront_chk #(.ADDR_W(ADDR_W), .NQ(NQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .byte_en(byte_en), .cc_en_bit(wdata[0]), .rd_valid(rd_valid),
    .rdata(rdata), .bell_valid(bell_valid), .bell_err(bell_err), .rdy(rdy_q)
);

// File: tb/tb_nvq_regfront.sv
// Scoreboard bench: driver tasks queue expected reads and doorbell events,
// a monitor at the falling edge pops and compares them as they appear.
module tb_nvq_regfront;
    localparam int ADDR_W = 13;
    localparam int NQ     = 2;
    localparam int PTR_W  = 16;
    localparam int QID_W  = (NQ > 1) ? $clog2(NQ) : 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [3:0]        byte_en = 4'hF;
    logic [31:0]       wdata = '0;
    logic              rd_valid;
    logic [31:0]       rdata;
    logic              bell_valid, bell_is_cq, bell_err;
    logic [QID_W-1:0]  bell_qid;
    logic [PTR_W-1:0]  bell_ptr;
    logic [63:0]       adm_sq_base, adm_cq_base;
    logic [11:0]       adm_sq_size, adm_cq_size;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_rd[$];
    string       exp_rd_req[$];
    logic [31:0] exp_bell[$];
    string       exp_bell_req[$];

    always #10 clk = ~clk;

    nvq_regfront #(.ADDR_W(ADDR_W), .NQ(NQ), .PTR_W(PTR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .byte_en(byte_en), .wdata(wdata), .rd_valid(rd_valid), .rdata(rdata),
        .bell_valid(bell_valid), .bell_qid(bell_qid), .bell_is_cq(bell_is_cq),
        .bell_ptr(bell_ptr), .bell_err(bell_err),
        .adm_sq_base(adm_sq_base), .adm_cq_base(adm_cq_base),
        .adm_sq_size(adm_sq_size), .adm_cq_size(adm_cq_size)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d; byte_en = be;
        @(negedge clk);
        wr_en = 1'b0; byte_en = 4'hF;
    endtask

    task automatic rd(input string req, input int a, input logic [31:0] exp,
                      input logic [3:0] be = 4'hF);
        exp_rd.push_back(exp);
        exp_rd_req.push_back(req);
        @(negedge clk);
        rd_en = 1'b1; addr = ADDR_W'(a); byte_en = be;
        @(negedge clk);
        rd_en = 1'b0; byte_en = 4'hF;
    endtask

    task automatic bell(input string req, input int q, input logic cq, input logic [31:0] d);
        exp_bell.push_back({8'(q), 7'b0, cq, d[15:0]});
        exp_bell_req.push_back(req);
        wr('h1000 + 8 * q + (cq ? 4 : 0), d);
    endtask

    // Monitor: compare each result strobe against the head of its queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid) begin
                checks++;
                if (exp_rd.size() == 0) begin
                    errors++;
                    $display("FAIL R12: unexpected read strobe actual=%h expected=none", rdata);
                end else begin
                    logic [31:0] e;
                    string r;
                    e = exp_rd.pop_front();
                    r = exp_rd_req.pop_front();
                    if (rdata !== e) begin
                        errors++;
                        $display("FAIL %s: read actual=%h expected=%h", r, rdata, e);
                    end
                end
            end
            if (bell_valid) begin
                logic [31:0] a;
                a = {8'(bell_qid), 7'b0, bell_is_cq, bell_ptr};
                checks++;
                if (exp_bell.size() == 0) begin
                    errors++;
                    $display("FAIL R10/R11: unexpected doorbell actual=%h expected=none", a);
                end else begin
                    logic [31:0] e;
                    string r;
                    e = exp_bell.pop_front();
                    r = exp_bell_req.pop_front();
                    if (a !== e) begin
                        errors++;
                        $display("FAIL %s: doorbell actual=%h expected=%h", r, a, e);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd("R1", 'h00, 32'h0A01_0010);
        rd("R1", 'h04, 32'h0);
        rd("R1", 'h08, 32'h0001_0000);
        rd("R1", 'h14, 32'h0);
        rd("R1", 'h1C, 32'h0);
        rd("R1", 'h24, 32'h0);
        check("R1 err", 64'(bell_err), 64'h0);
        check("R1 adm base", adm_sq_base, 64'h0);

        // R2 unmapped and read-only offsets
        rd("R2", 'h18, 32'h0);
        rd("R2", 'h40, 32'h0);
        rd("R2", 'h26, 32'h0);
        wr('h00, 32'hFFFF_FFFF);
        rd("R2", 'h00, 32'h0A01_0010);
        wr('h1C, 32'hF);
        rd("R2", 'h1C, 32'h0);
        wr('h08, 32'h0);
        rd("R2", 'h08, 32'h0001_0000);

        // R5 attribute and base masking
        wr('h24, 32'hFFFF_FFFF);
        rd("R5", 'h24, 32'h0FFF_0FFF);
        wr('h24, 32'h001F_0007);
        rd("R5", 'h24, 32'h001F_0007);
        wr('h28, 32'h1234_5ABC);
        rd("R5", 'h28, 32'h1234_5000);
        wr('h2C, 32'hDEAD_BEEF);
        rd("R5", 'h2C, 32'hDEAD_BEEF);
        wr('h30, 32'h0000_FFFF);
        rd("R5", 'h30, 32'h0000_F000);
        wr('h34, 32'h0000_0001);
        rd("R5", 'h34, 32'h0000_0001);

        // R3 partial byte enables
        wr('h24, 32'h0, 4'h3);
        rd("R3", 'h24, 32'h001F_0007);
        rd("R3", 'h08, 32'h0, 4'h1);

        // R4 interrupt mask set/clear
        wr('h0C, 32'h5);
        rd("R4", 'h0C, 32'h5);
        wr('h0C, 32'h30);
        rd("R4", 'h10, 32'h35);
        wr('h10, 32'h11);
        rd("R4", 'h10, 32'h24);

        // R6 configuration field keep mask; shutdown 3 does nothing (R9)
        wr('h14, 32'hFFFF_FFFE);
        rd("R6", 'h14, 32'h00FF_FFF0);
        rd("R9", 'h1C, 32'h0);
        wr('h14, 32'h0046_0000);
        rd("R6", 'h14, 32'h0046_0000);

        // R7 enable rising edge
        wr('h14, 32'h0046_0001);
        rd("R7", 'h1C, 32'h1);
        rd("R7", 'h0C, 32'h0);
        rd("R7", 'h14, 32'h0046_0001);
        check("R7 sq base", adm_sq_base, 64'hDEAD_BEEF_1234_5000);
        check("R7 cq base", adm_cq_base, 64'h0000_0001_0000_F000);
        check("R7 sq size", 64'(adm_sq_size), 64'h007);
        check("R7 cq size", 64'(adm_cq_size), 64'h01F);
        wr('h28, 32'h0);
        check("R7 snapshot held", adm_sq_base, 64'hDEAD_BEEF_1234_5000);
        wr('h0C, 32'h3);
        wr('h14, 32'h0046_0001);
        rd("R7", 'h0C, 32'h3);

        // R9 normal shutdown, then no-effect request
        wr('h14, 32'h0046_4001);
        rd("R9", 'h1C, 32'h9);
        wr('h14, 32'h0046_0001);
        rd("R9", 'h1C, 32'h9);

        // R8 enable falling edge, then R9 enable edge clears shutdown status
        wr('h14, 32'h0046_0000);
        rd("R8", 'h1C, 32'h8);
        wr('h14, 32'h0046_0001);
        rd("R9", 'h1C, 32'h1);

        // R10 doorbell decode for both queues and kinds
        bell("R10", 0, 1'b0, 32'h0000_0005);
        bell("R10", 0, 1'b1, 32'h0000_0003);
        bell("R10", 1, 1'b0, 32'hABCD_1234);
        bell("R10", 1, 1'b1, 32'h0000_000F);
        wr('h1002, 32'h1);
        wr('h1000, 32'h7, 4'h3);
        repeat (2) @(negedge clk);
        check("R10 misaligned no err", 64'(bell_err), 64'h0);

        // R11 out-of-range doorbells
        wr('h1010, 32'h7);
        repeat (2) @(negedge clk);
        check("R11 err set", 64'(bell_err), 64'h1);
        wr('h1FF8, 32'h1);
        bell("R11", 0, 1'b0, 32'h0000_0009);
        check("R11 err sticky", 64'(bell_err), 64'h1);

        repeat (4) @(negedge clk);
        check("R12 reads drained", 64'(exp_rd.size()), 64'h0);
        check("R10 events drained", 64'(exp_bell.size()), 64'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule